// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch Sequencer with Address Halt

This block is the control sequencer of a small 32-bit integer core whose instruction store is only one byte wide. For each instruction it reads four consecutive bytes, one read at a time, and assembles them into a little-endian word. It offers that word to an execute unit and holds it there until the unit signals completion. It then commits the next program counter and, as the last step of every instruction, decides whether to stop.

The execute unit reports completion together with a redirect flag and a target address. A taken branch or a jump sets the flag, and the target becomes the new PC exactly as given. Every other instruction moves the PC on by four. All PC arithmetic wraps around the 32-bit address space.

A halt configuration selects between running forever and stopping at a given address. Once stopped, the sequencer stays idle and reports that it has halted until the next reset.

Top module: `byte_fetch_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC loads from `reset_pc_i` and `halted_o` clears. After that edge, `rd_valid_o` is 1, `rd_addr_o` equals the reset vector, and `instr_valid_o` is 0.
- R2: The four bytes of an instruction are read from PC, PC+1, PC+2 and PC+3, in that order, with addresses wrapping modulo 2^32.
- R3: Only one byte read is in flight. While `rd_valid_o` is 1 and `rd_ready_i` is 0, both `rd_valid_o` and `rd_addr_o` hold. A byte is taken from `rd_data_i` only on a cycle where `rd_valid_o` and `rd_ready_i` are both 1.
- R4: The word on `instr_o` is little-endian. The byte from PC sits in bits 7:0 and the byte from PC+3 in bits 31:24. `instr_valid_o`, `instr_o` and `instr_pc_o` hold until `exec_done_i` is seen.
- R5: When `exec_done_i` is accepted with `exec_redirect_i` at 0, the next instruction starts at PC+4, modulo 2^32.
- R6: When `exec_done_i` is accepted with `exec_redirect_i` at 1, the next instruction starts at `exec_target_i`, and no 4 is added.
- R7: With `halt_mode_i` at 0 (run forever), the sequencer never halts, even when the committed PC equals `halt_addr_i`.
- R8: With `halt_mode_i` at 1 (stop at address), the sequencer halts once a committed PC equals `halt_addr_i`. The comparison is made only after a commit, so a reset vector equal to the halt address still runs the instruction at that address.
- R9: Once `halted_o` is 1, it stays 1 until reset, even if the halt configuration changes. While it is 1, `rd_valid_o` and `instr_valid_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reset_pc_i | input | 32 | PC loaded during reset |
| halt_mode_i | input | 1 | 0 = run forever, 1 = stop at `halt_addr_i` |
| halt_addr_i | input | 32 | Address whose commit stops the sequencer |
| rd_valid_o | output | 1 | Byte read request |
| rd_addr_o | output | 32 | Byte address of the request |
| rd_ready_i | input | 1 | Memory accepts the request this cycle, data on `rd_data_i` |
| rd_data_i | input | 8 | Byte returned with `rd_ready_i` |
| instr_valid_o | output | 1 | Assembled instruction offered to execute |
| instr_o | output | 32 | Assembled instruction word |
| instr_pc_o | output | 32 | Address of the offered instruction |
| exec_done_i | input | 1 | Execute unit finished the offered instruction |
| exec_redirect_i | input | 1 | The finished instruction wrote the PC itself |
| exec_target_i | input | 32 | New PC when the redirect flag is set |
| halted_o | output | 1 | Sequencer has stopped |

## Verification
The assertions assume that `rd_ready_i` has meaning only while a read is requested, and that `exec_done_i` is a one-cycle pulse given only while an instruction is offered, with the redirect flag and target valid in that same cycle. The stimulus drives the memory side from a fixed ready pattern that inserts stalls and returns the byte for the presented address. The execute model raises done for one cycle after a PC-dependent delay, and only while `instr_valid_o` is high. Redirects come from a rule on the PC, so jumps, wrap-around targets and halts reached by either path all occur.

// File: rtl/fetch_seq_pkg.sv
// Package: shared types for the byte-serial fetch sequencer.
// Assumes: one outstanding instruction, four phases per instruction.
package fetch_seq_pkg;

    // Sequencer phase of the current instruction
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_CHECK = 2'd2,
        ST_HALT  = 2'd3
    } seq_state_t;

    // Encodings of the halt mode input
    localparam logic HALT_RUN_FOREVER = 1'b0;
    localparam logic HALT_AT_ADDRESS  = 1'b1;

endpackage

// File: rtl/fetch_byte_assembler.sv
// Module: fetch_byte_assembler
// Reads the bytes of one instruction one at a time, starting at base_pc_i,
// and stores each byte in the lane that matches its offset, which gives a
// little-endian word.
// Assumes: base_pc_i is stable while fetch_en_i is high, and rd_ready_i
// returns rd_data_i for the presented address in the same cycle.
module fetch_byte_assembler #(
    parameter int XLEN   = 32,
    parameter int BYTE_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_en_i,
    input  logic [XLEN-1:0] base_pc_i,
    output logic            rd_valid_o,
    output logic [XLEN-1:0] rd_addr_o,
    input  logic            rd_ready_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [XLEN-1:0] word_o,
    output logic            word_done_o
);
    localparam int N_BYTES = XLEN / BYTE_W;
    localparam int IDX_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

    logic [IDX_W-1:0] idx_q;
    logic             accept;
    logic             at_last;

    // Handshake decode for the byte in flight
    always_comb begin
        rd_valid_o  = fetch_en_i;
        rd_addr_o   = base_pc_i + XLEN'(idx_q);
        accept      = fetch_en_i && rd_ready_i;
        at_last     = (idx_q == LAST_IDX);
        word_done_o = accept && at_last;
    end

    // Byte offset within the instruction, advanced once per accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= at_last ? '0 : idx_q + 1'b1;
        end
    end

    // One storage lane per byte offset
    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        // Capture the byte whose offset matches this lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (accept && (idx_q == IDX_W'(g))) begin
                lane_q <= rd_data_i;
            end
        end

        assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o))); // R3

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !at_last) |=> (rd_addr_o == $past(rd_addr_o) + XLEN'(1))); // R2

endmodule

// File: rtl/seq_pc_register.sv
// Module: seq_pc_register
// Holds the program counter. It loads the reset vector during reset and
// commits either the sequential successor or the redirect target when the
// execute unit finishes.
// Assumes: commit_i is a one-cycle pulse per instruction.
module seq_pc_register #(
    parameter int XLEN        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] reset_pc_i,
    input  logic            commit_i,
    input  logic            redirect_i,
    input  logic [XLEN-1:0] target_i,
    output logic [XLEN-1:0] pc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;

    // Successor address: the target for a redirect, else the next instruction
    always_comb begin
        pc_next = redirect_i ? target_i : (pc_q + STEP);
    end

    // PC register with reset vector load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= reset_pc_i;
        end else if (commit_i) begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !redirect_i) |=> (pc_o == $past(pc_o) + STEP)); // R5

    AST_REDIRECT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && redirect_i) |=> (pc_o == $past(target_i))); // R6

    AST_PC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(pc_o)); // R4

endmodule

// File: rtl/seq_halt_match.sv
// Module: seq_halt_match
// Decides, from the halt mode and address, whether a committed PC stops
// the sequencer.
// Assumes: only sampled in the check phase that follows a PC commit.
module seq_halt_match
    import fetch_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            mode_i,
    input  logic [XLEN-1:0] halt_addr_i,
    input  logic [XLEN-1:0] pc_i,
    output logic            stop_o
);
    // Address equality counts only in stop-at-address mode
    always_comb begin
        stop_o = (mode_i == HALT_AT_ADDRESS) && (pc_i == halt_addr_i);
    end

endmodule

// File: rtl/byte_fetch_sequencer.sv
// Module: byte_fetch_sequencer (top)
// Steps each instruction through four phases: byte fetch, execute
// handshake, PC commit and halt check. After a halt it stays idle until
// reset.
// Assumes: exec_done_i is a one-cycle pulse while instr_valid_o is high,
// with exec_redirect_i and exec_target_i valid in the same cycle.
module byte_fetch_sequencer
    import fetch_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   reset_pc_i,
    input  logic              halt_mode_i,
    input  logic [XLEN-1:0]   halt_addr_i,
    output logic              rd_valid_o,
    output logic [XLEN-1:0]   rd_addr_o,
    input  logic              rd_ready_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              instr_valid_o,
    output logic [XLEN-1:0]   instr_o,
    output logic [XLEN-1:0]   instr_pc_o,
    input  logic              exec_done_i,
    input  logic              exec_redirect_i,
    input  logic [XLEN-1:0]   exec_target_i,
    output logic              halted_o
);
    localparam int INSTR_BYTES = XLEN / BYTE_W;

    seq_state_t      state_q;
    seq_state_t      state_d;
    logic            fetch_en;
    logic            word_done;
    logic            commit;
    logic            stop;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] word;

    fetch_byte_assembler #(
        .XLEN   (XLEN),
        .BYTE_W (BYTE_W)
    ) u_assembler (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_en_i  (fetch_en),
        .base_pc_i   (pc),
        .rd_valid_o  (rd_valid_o),
        .rd_addr_o   (rd_addr_o),
        .rd_ready_i  (rd_ready_i),
        .rd_data_i   (rd_data_i),
        .word_o      (word),
        .word_done_o (word_done)
    );

    seq_pc_register #(
        .XLEN        (XLEN),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .reset_pc_i (reset_pc_i),
        .commit_i   (commit),
        .redirect_i (exec_redirect_i),
        .target_i   (exec_target_i),
        .pc_o       (pc)
    );

    seq_halt_match #(
        .XLEN (XLEN)
    ) u_halt (
        .mode_i      (halt_mode_i),
        .halt_addr_i (halt_addr_i),
        .pc_i        (pc),
        .stop_o      (stop)
    );

    // Phase decode to the outputs and the sub-block enables
    always_comb begin
        fetch_en      = (state_q == ST_FETCH);
        instr_valid_o = (state_q == ST_EXEC);
        commit        = (state_q == ST_EXEC) && exec_done_i;
        halted_o      = (state_q == ST_HALT);
        instr_o       = word;
        instr_pc_o    = pc;
    end

    // Next phase: fetch -> execute -> check -> fetch or halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: if (word_done)   state_d = ST_EXEC;
            ST_EXEC:  if (exec_done_i) state_d = ST_CHECK;
            ST_CHECK: state_d = stop ? ST_HALT : ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_FETCH;
        endcase
    end

    // Phase register, restarting the fetch on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    AST_INSTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_o && !exec_done_i) |=>
            (instr_valid_o && $stable(instr_o) && $stable(instr_pc_o))); // R4

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o); // R9

    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (!rd_valid_o && !instr_valid_o)); // R9

    AST_HALT_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_o) |-> ($past(state_q) == ST_CHECK)); // R8

    AST_RUN_FOREVER: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && halt_mode_i == HALT_RUN_FOREVER) |=> !halted_o); // R7

endmodule

// File: tb/byte_fetch_sequencer_tb_top.sv
`timescale 1ns/1ps
module byte_fetch_sequencer_tb_top;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] word;
        logic        redir;
        logic [31:0] tgt;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] reset_pc_i = 32'h0;
    logic        halt_mode_i = 1'b0;
    logic [31:0] halt_addr_i = 32'h0;
    logic        rd_valid_o;
    logic [31:0] rd_addr_o;
    logic        rd_ready_i = 1'b0;
    logic [7:0]  rd_data_i = 8'h0;
    logic        instr_valid_o;
    logic [31:0] instr_o;
    logic [31:0] instr_pc_o;
    logic        exec_done_i = 1'b0;
    logic        exec_redirect_i = 1'b0;
    logic [31:0] exec_target_i = 32'h0;
    logic        halted_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    byte_fetch_sequencer dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .reset_pc_i      (reset_pc_i),
        .halt_mode_i     (halt_mode_i),
        .halt_addr_i     (halt_addr_i),
        .rd_valid_o      (rd_valid_o),
        .rd_addr_o       (rd_addr_o),
        .rd_ready_i      (rd_ready_i),
        .rd_data_i       (rd_data_i),
        .instr_valid_o   (instr_valid_o),
        .instr_o         (instr_o),
        .instr_pc_o      (instr_pc_o),
        .exec_done_i     (exec_done_i),
        .exec_redirect_i (exec_redirect_i),
        .exec_target_i   (exec_target_i),
        .halted_o        (halted_o)
    );

    // Memory contents, computed from the address
    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] * 8'd29 + 8'd7) ^ a[31:24] ^ a[15:8];
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {mem_byte(a + 32'd3), mem_byte(a + 32'd2),
                mem_byte(a + 32'd1), mem_byte(a)};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder: ready pattern with stalls, byte for the presented address
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            rd_ready_i = (cyc % 3) != 1;
            rd_data_i  = mem_byte(rd_addr_o);
        end
    end

    // Monitor and execute model: pops the scoreboard at each completion
    initial begin
        int wait_cnt = 0;
        item_t it;
        forever begin
            @(negedge clk);
            if (exec_done_i) begin
                exec_done_i     = 1'b0;
                exec_redirect_i = 1'b0;
                wait_cnt        = 0;
            end else if (instr_valid_o && rst_n) begin
                wait_cnt++;
                if (wait_cnt >= (instr_pc_o[3] ? 1 : 3) && sb_q.size() > 0) begin
                    it = sb_q.pop_front();
                    chk(instr_pc_o == it.pc, "R2 R5 R6 instr_pc", instr_pc_o, it.pc);
                    chk(instr_o == it.word, "R4 little-endian word", instr_o, it.word);
                    exec_done_i     = 1'b1;
                    exec_redirect_i = it.redir;
                    exec_target_i   = it.tgt;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    // Driver: reset the sequencer, then queue the instructions the requirements predict
    task automatic run_case(input logic [31:0] start, input logic mode,
                            input logic [31:0] haddr, input int max_n);
        logic [31:0] pc = start;
        logic [31:0] nxt;
        bit          will_halt = 0;
        item_t       it;
        int          guard;
        @(negedge clk);
        rst_n       = 1'b0;
        reset_pc_i  = start;
        halt_mode_i = mode;
        halt_addr_i = haddr;
        sb_q.delete();
        @(negedge clk);
        chk(rd_valid_o == 1'b1, "R1 rd_valid in reset", 32'(rd_valid_o), 32'd1);
        chk(rd_addr_o == start, "R1 first address", rd_addr_o, start);
        chk(halted_o == 1'b0, "R1 halted cleared", 32'(halted_o), 32'd0);
        chk(instr_valid_o == 1'b0, "R1 no instr in reset", 32'(instr_valid_o), 32'd0);
        for (int i = 0; i < max_n; i++) begin
            it.pc    = pc;
            it.word  = mem_word(pc);
            it.redir = (pc[5:2] == 4'd6);
            it.tgt   = pc + 32'h30;
            sb_q.push_back(it);
            nxt = it.redir ? it.tgt : pc + 32'd4;
            pc  = nxt;
            if (mode && nxt == haddr) begin
                will_halt = 1;
                break;
            end
        end
        rst_n = 1'b1;
        guard = 0;
        while (sb_q.size() > 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (12) @(negedge clk);
        chk(sb_q.size() == 0, "R4 all instructions executed", 32'(sb_q.size()), 32'd0);
        if (will_halt) begin
            chk(halted_o == 1'b1, "R8 halted at address", 32'(halted_o), 32'd1);
            chk(rd_valid_o == 1'b0, "R9 no fetch when halted", 32'(rd_valid_o), 32'd0);
            chk(instr_valid_o == 1'b0, "R9 no exec when halted", 32'(instr_valid_o), 32'd0);
            halt_mode_i = 1'b0;
            halt_addr_i = ~haddr;
            repeat (8) @(negedge clk);
            chk(halted_o == 1'b1, "R9 halt sticky", 32'(halted_o), 32'd1);
            chk(rd_valid_o == 1'b0, "R9 still idle", 32'(rd_valid_o), 32'd0);
        end else begin
            chk(halted_o == 1'b0, mode ? "R8 no halt before commit" : "R7 never halts",
                32'(halted_o), 32'd0);
            chk(instr_valid_o == 1'b1, "R3 R4 next instruction waiting",
                32'(instr_valid_o), 32'd1);
            chk(instr_pc_o == pc, "R5 R6 next pc", instr_pc_o, pc);
        end
    endtask

    // Stimulus sequence
    initial begin
        repeat (3) @(negedge clk);
        run_case(32'h0000_0100, 1'b0, 32'h0000_0108, 10); // R7, passes 0x108 and a jump
        run_case(32'h0000_0200, 1'b1, 32'h0000_0210, 20); // R8 sequential stop
        run_case(32'h0000_0200, 1'b1, 32'h0000_0248, 20); // R6 R8 stop on jump target
        run_case(32'hFFFF_FFF8, 1'b1, 32'h0000_0004, 20); // R5 wrap of PC+4
        run_case(32'hFFFF_FFFE, 1'b1, 32'h0000_0002, 20); // R2 byte address wrap
        run_case(32'hFFFF_FFD8, 1'b1, 32'h0000_0008, 20); // R6 wrapping target
        run_case(32'h0000_0300, 1'b1, 32'h0000_0300, 5);  // R8 vector equals halt address
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule